// File: doc/BRIEF.md
# White Balance Frame Statistics Accumulator

This block watches a raw Bayer colour-filter-array pixel stream and, over one frame, collects the statistics a quadratic white-balance fit needs. Each pixel belongs to exactly one colour plane. The plane is fixed by the pixel's row and column parity in an RGGB layout. For the red and blue planes the block keeps the running sum of the pixel values, the running sum of their squares, the largest value and the largest square. For green it keeps only the sum and the largest value, and both green sites of the 2x2 cell feed the same green statistics.

A frame is delimited by a start marker on its first pixel and an end marker on its last pixel. Both markers count only while `valid_i` is high. One cycle after the final pixel is accepted, all statistics are copied into output registers and a one-cycle done pulse is raised. The outputs then hold until the next frame completes. Solving for the correction coefficients and applying them to pixels belong to other blocks.

Top module: `wb_stats_accum`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first frame completes, every statistic output is zero and `done_o` is low.
- R2: The start-marked pixel is at row 0, column 0. The column advances on each accepted pixel and wraps after COLS pixels, which toggles the row parity. The plane is chosen by (row parity, column parity): (even, even) is red, (odd, odd) is blue, and the two mixed cases are green.
- R3: For red and blue, the sum output equals the sum of that plane's pixel values and the square-sum output equals the sum of their squares. The widths are PIX_W+17 and 2*PIX_W+17 bits, so a full-scale 320x240 frame does not overflow.
- R4: For red and blue, the max output is the largest pixel value of the plane in the frame and the square-max output is the largest squared value.
- R5: Green sum and green max cover the pixels at both green sites, and green has no squared statistics.
- R6: A start-marked valid pixel discards everything gathered before it. A frame that is restarted without an end marker leaves the outputs unchanged.
- R7: The outputs change, and `done_o` is high for exactly one cycle, only in the cycle after an end-marked valid pixel is accepted. At all other times the outputs hold.
- R8: Cycles with `valid_i` low change nothing, including any start or end marker raised in those cycles.
- R9: A pixel carrying both markers forms a complete one-pixel frame: red statistics of that pixel alone, all other planes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel qualifier |
| sof_i | input | 1 | First pixel of frame (with valid_i) |
| eof_i | input | 1 | Last pixel of frame (with valid_i) |
| pix_i | input | PIX_W | Raw pixel value |
| red_sum_o | output | PIX_W+17 | Red value sum |
| red_sq_sum_o | output | 2*PIX_W+17 | Red square sum |
| red_max_o | output | PIX_W | Red maximum |
| red_sq_max_o | output | 2*PIX_W | Red maximum square |
| green_sum_o | output | PIX_W+17 | Green value sum |
| green_max_o | output | PIX_W | Green maximum |
| blue_sum_o | output | PIX_W+17 | Blue value sum |
| blue_sq_sum_o | output | 2*PIX_W+17 | Blue square sum |
| blue_max_o | output | PIX_W | Blue maximum |
| blue_sq_max_o | output | 2*PIX_W | Blue maximum square |
| done_o | output | 1 | One-cycle results-ready pulse |

## Verification
The clearing of the accumulators on a start marker and the latching of results on an end marker can fall in the same cycle. The bench provokes this with one-pixel frames that carry both markers, and expects statistics for that single red pixel only, with no trace of the previous frame. A second collision is a marker raised while `valid_i` is low in the middle of a frame. Random gaps in the stimulus carry such stray markers, and the bench expects `done_o` to stay low and the final sums to match a model that skips those cycles.

// File: rtl/wb_stats_pkg.sv
package wb_stats_pkg;
  typedef enum logic [1:0] {
    PL_RED   = 2'd0,
    PL_GREEN = 2'd1,
    PL_BLUE  = 2'd2
  } plane_e;

  localparam int unsigned EXT_W = 17;  // headroom bits for 320x240 accumulation

  function automatic plane_e site_plane(input logic row_odd, input logic col_odd);
    unique case ({row_odd, col_odd})
      2'b00:   return PL_RED;
      2'b11:   return PL_BLUE;
      default: return PL_GREEN;
    endcase
  endfunction
endpackage

// File: rtl/wb_bayer_phase.sv
module wb_bayer_phase
  import wb_stats_pkg::*;
#(
  parameter int unsigned COLS = 320
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  logic   sof_i,
  output plane_e plane_o
);
  localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [COL_W-1:0] col_q, col_cur, col_nx;
  logic             row_q, row_cur, row_nx;

  // start marker forces the cell origin for the current pixel
  always_comb begin
    col_cur = sof_i ? '0 : col_q;
    row_cur = sof_i ? 1'b0 : row_q;
    if (col_cur == COL_LAST) begin
      col_nx = '0;
      row_nx = ~row_cur;
    end else begin
      col_nx = col_cur + 1'b1;
      row_nx = row_cur;
    end
  end

  assign plane_o = site_plane(row_cur, col_cur[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= 1'b0;
    end else if (valid_i) begin
      col_q <= col_nx;
      row_q <= row_nx;
    end
  end
endmodule

// File: rtl/wb_sum_max.sv
module wb_sum_max #(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned ACC_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic             latch_i,
  input  logic [IN_W-1:0]  val_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [IN_W-1:0]  max_o
);
  logic [ACC_W-1:0] acc_q, acc_base, acc_nx, sum_q;
  logic [IN_W-1:0]  pk_q, pk_base, pk_nx, max_q;

  always_comb begin
    acc_base = clr_i ? '0 : acc_q;
    pk_base  = clr_i ? '0 : pk_q;
    acc_nx   = acc_base + (hit_i ? ACC_W'(val_i) : '0);
    pk_nx    = (hit_i && (val_i > pk_base)) ? val_i : pk_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      pk_q  <= '0;
      sum_q <= '0;
      max_q <= '0;
    end else begin
      if (en_i) begin
        acc_q <= acc_nx;
        pk_q  <= pk_nx;
      end
      // results include the closing pixel
      if (latch_i) begin
        sum_q <= acc_nx;
        max_q <= pk_nx;
      end
    end
  end

  assign sum_o = sum_q;
  assign max_o = max_q;
endmodule

// File: rtl/wb_stats_accum.sv
module wb_stats_accum
  import wb_stats_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned COLS  = 320,
  parameter int unsigned SUM_W = PIX_W + EXT_W,
  parameter int unsigned SQ_W  = 2 * PIX_W,
  parameter int unsigned SQS_W = 2 * PIX_W + EXT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [SUM_W-1:0] red_sum_o,
  output logic [SQS_W-1:0] red_sq_sum_o,
  output logic [PIX_W-1:0] red_max_o,
  output logic [SQ_W-1:0]  red_sq_max_o,
  output logic [SUM_W-1:0] green_sum_o,
  output logic [PIX_W-1:0] green_max_o,
  output logic [SUM_W-1:0] blue_sum_o,
  output logic [SQS_W-1:0] blue_sq_sum_o,
  output logic [PIX_W-1:0] blue_max_o,
  output logic [SQ_W-1:0]  blue_sq_max_o,
  output logic             done_o
);
  localparam int unsigned N_RB = 2;

  plane_e          plane;
  logic            clr, latch;
  logic [SQ_W-1:0] pix_sq;
  logic            done_q;

  logic [SUM_W-1:0] rb_sum [N_RB];
  logic [SQS_W-1:0] rb_sqs [N_RB];
  logic [PIX_W-1:0] rb_max [N_RB];
  logic [SQ_W-1:0]  rb_sqm [N_RB];

  assign clr   = valid_i & sof_i;
  assign latch = valid_i & eof_i;

  // one squarer serves red and blue: at most one of them per cycle
  assign pix_sq = SQ_W'(pix_i) * SQ_W'(pix_i);

  wb_bayer_phase #(.COLS(COLS)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sof_i   (sof_i),
    .plane_o (plane)
  );

  for (genvar i = 0; i < N_RB; i++) begin : g_rb
    localparam plane_e PL = (i == 0) ? PL_RED : PL_BLUE;
    logic hit;
    assign hit = valid_i && (plane == PL);

    wb_sum_max #(.IN_W(PIX_W), .ACC_W(SUM_W)) u_lin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (valid_i),
      .clr_i   (clr),
      .hit_i   (hit),
      .latch_i (latch),
      .val_i   (pix_i),
      .sum_o   (rb_sum[i]),
      .max_o   (rb_max[i])
    );

    wb_sum_max #(.IN_W(SQ_W), .ACC_W(SQS_W)) u_sq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (valid_i),
      .clr_i   (clr),
      .hit_i   (hit),
      .latch_i (latch),
      .val_i   (pix_sq),
      .sum_o   (rb_sqs[i]),
      .max_o   (rb_sqm[i])
    );
  end

  logic g_hit;
  assign g_hit = valid_i && (plane == PL_GREEN);

  wb_sum_max #(.IN_W(PIX_W), .ACC_W(SUM_W)) u_green (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (valid_i),
    .clr_i   (clr),
    .hit_i   (g_hit),
    .latch_i (latch),
    .val_i   (pix_i),
    .sum_o   (green_sum_o),
    .max_o   (green_max_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= latch;
  end

  assign done_o        = done_q;
  assign red_sum_o     = rb_sum[0];
  assign red_sq_sum_o  = rb_sqs[0];
  assign red_max_o     = rb_max[0];
  assign red_sq_max_o  = rb_sqm[0];
  assign blue_sum_o    = rb_sum[1];
  assign blue_sq_sum_o = rb_sqs[1];
  assign blue_max_o    = rb_max[1];
  assign blue_sq_max_o = rb_sqm[1];
endmodule

// File: rtl/wb_stats_accum_chk.sv
module wb_stats_accum_chk #(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned SUM_W = 27,
  parameter int unsigned SQ_W  = 20,
  parameter int unsigned SQS_W = 37
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             sof_i,
  input logic             eof_i,
  input logic [PIX_W-1:0] pix_i,
  input logic [SUM_W-1:0] red_sum_o,
  input logic [SQS_W-1:0] red_sq_sum_o,
  input logic [PIX_W-1:0] red_max_o,
  input logic [SQ_W-1:0]  red_sq_max_o,
  input logic [SUM_W-1:0] green_sum_o,
  input logic [PIX_W-1:0] green_max_o,
  input logic [SUM_W-1:0] blue_sum_o,
  input logic [SQS_W-1:0] blue_sq_sum_o,
  input logic [PIX_W-1:0] blue_max_o,
  input logic [SQ_W-1:0]  blue_sq_max_o,
  input logic             done_o
);
  p_done_after_eof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> done_o);

  p_no_stray_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && eof_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(red_sum_o) && $stable(red_sq_sum_o) && $stable(red_max_o)
                 && $stable(green_sum_o) && $stable(green_max_o)
                 && $stable(blue_sum_o) && $stable(blue_sq_sum_o) && $stable(blue_max_o)));

  p_sq_max_red_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (red_sq_max_o == SQ_W'(red_max_o) * SQ_W'(red_max_o)));

  p_sq_max_blue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (blue_sq_max_o == SQ_W'(blue_max_o) * SQ_W'(blue_max_o)));

  p_sum_ge_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (red_sum_o >= SUM_W'(red_max_o) && blue_sum_o >= SUM_W'(blue_max_o)
                && red_sq_sum_o >= SQS_W'(red_sq_max_o) && blue_sq_sum_o >= SQS_W'(blue_sq_max_o)));

  p_green_sum_ge_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (green_sum_o >= SUM_W'(green_max_o)));

  always_comb begin
    if (!rst_ni) p_reset_clear_r1: assert (done_o == 1'b0 && red_sum_o == '0 && green_sum_o == '0 && blue_sum_o == '0);
  end
endmodule

bind wb_stats_accum wb_stats_accum_chk #(
  .PIX_W(PIX_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .SQS_W(SQS_W)
) chk_i (.*);

// File: tb/wb_stats_accum_tb_top.sv
module wb_stats_accum_tb_top;
  localparam int PIX_W = 10;
  localparam int COLS  = 320;
  localparam int ROWS  = 240;
  localparam int SUM_W = PIX_W + 17;
  localparam int SQ_W  = 2 * PIX_W;
  localparam int SQS_W = 2 * PIX_W + 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic [SUM_W-1:0] red_sum_o, green_sum_o, blue_sum_o;
  logic [SQS_W-1:0] red_sq_sum_o, blue_sq_sum_o;
  logic [PIX_W-1:0] red_max_o, green_max_o, blue_max_o;
  logic [SQ_W-1:0]  red_sq_max_o, blue_sq_max_o;
  logic done_o;

  always #2.5 clk = ~clk;

  wb_stats_accum dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i), .eof_i(eof_i), .pix_i(pix_i),
    .red_sum_o(red_sum_o), .red_sq_sum_o(red_sq_sum_o), .red_max_o(red_max_o), .red_sq_max_o(red_sq_max_o),
    .green_sum_o(green_sum_o), .green_max_o(green_max_o),
    .blue_sum_o(blue_sum_o), .blue_sq_sum_o(blue_sq_sum_o), .blue_max_o(blue_max_o), .blue_sq_max_o(blue_sq_max_o),
    .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  // expected results of the last completed frame: [0]=red [1]=green [2]=blue
  longint e_sum[3], e_sqs[3], e_max[3], e_sqm[3];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int plane_of(input int k);
    int col = k % COLS;
    int row = (k / COLS) % 2;
    if (row == 0 && col % 2 == 0) return 0;
    if (row == 1 && col % 2 == 1) return 2;
    return 1;
  endfunction

  function automatic int gen_pix(input int kind, input int k);
    case (kind)
      1:       return (1 << PIX_W) - 1;
      2:       return k % (1 << PIX_W);
      default: return int'($urandom % (1 << PIX_W));
    endcase
  endfunction

  task automatic check_outputs(input string req);
    chk(req, "red_sum",   longint'(red_sum_o),     e_sum[0]);
    chk(req, "red_sqs",   longint'(red_sq_sum_o),  e_sqs[0]);
    chk(req, "red_max",   longint'(red_max_o),     e_max[0]);
    chk(req, "red_sqm",   longint'(red_sq_max_o),  e_sqm[0]);
    chk(req, "green_sum", longint'(green_sum_o),   e_sum[1]);
    chk(req, "green_max", longint'(green_max_o),   e_max[1]);
    chk(req, "blue_sum",  longint'(blue_sum_o),    e_sum[2]);
    chk(req, "blue_sqs",  longint'(blue_sq_sum_o), e_sqs[2]);
    chk(req, "blue_max",  longint'(blue_max_o),    e_max[2]);
    chk(req, "blue_sqm",  longint'(blue_sq_max_o), e_sqm[2]);
  endtask

  // drives one frame of n pixels; end_it=0 abandons it without an end marker
  task automatic frame(input int n, input int kind, input int gap_pct, input bit end_it, input string req);
    longint f_sum[3], f_sqs[3], f_max[3], f_sqm[3];
    for (int p = 0; p < 3; p++) begin
      f_sum[p] = 0; f_sqs[p] = 0; f_max[p] = 0; f_sqm[p] = 0;
    end
    for (int k = 0; k < n; k++) begin
      int v  = gen_pix(kind, k);
      int pl = plane_of(k);
      longint sq = longint'(v) * longint'(v);
      f_sum[pl] += v;
      f_sqs[pl] += sq;
      if (v > f_max[pl]) f_max[pl] = v;
      if (sq > f_sqm[pl]) f_sqm[pl] = sq;
      @(negedge clk);
      valid_i = 1'b1;
      pix_i   = PIX_W'(v);
      sof_i   = (k == 0);
      eof_i   = end_it && (k == n - 1);
      if (k != n - 1 && int'($urandom % 100) < gap_pct) begin
        int idle = 1 + int'($urandom % 3);
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          if (g > 0) chk("R8", "done during gap", longint'(done_o), 0);
          valid_i = 1'b0;
          pix_i   = PIX_W'($urandom);
          sof_i   = $urandom % 2;  // stray markers while not valid
          eof_i   = $urandom % 2;
        end
      end
    end
    @(negedge clk);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
    if (end_it) begin
      for (int p = 0; p < 3; p++) begin
        e_sum[p] = f_sum[p]; e_sqs[p] = f_sqs[p]; e_max[p] = f_max[p];
        e_sqm[p] = (p == 1) ? 0 : f_sqm[p];
        if (p == 1) e_sqs[p] = 0;
      end
      chk("R7", "done pulse", longint'(done_o), 1);
      check_outputs(req);
      @(negedge clk);
      chk("R7", "done one cycle", longint'(done_o), 0);
      check_outputs("R7");
    end else begin
      chk("R6", "no done on abandon", longint'(done_o), 0);
      check_outputs("R6");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0b1a));
    for (int p = 0; p < 3; p++) begin
      e_sum[p] = 0; e_sqs[p] = 0; e_max[p] = 0; e_sqm[p] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(done_o), 0);
    check_outputs("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "done after reset", longint'(done_o), 0);
    check_outputs("R1");

    // R9: one-pixel frame, both markers on the same beat
    frame(1, 0, 0, 1'b1, "R9");
    // R2 R5: row wrap crosses into green/blue rows
    frame(COLS + 5, 2, 0, 1'b1, "R2");
    // R6: abandoned frame then restart
    frame(57, 0, 20, 1'b0, "R6");
    frame(3 * COLS + 11, 0, 30, 1'b1, "R6");
    // R8: heavy gaps with stray markers
    frame(700, 0, 60, 1'b1, "R8");
    frame(2, 0, 0, 1'b1, "R5");
    frame(1, 1, 0, 1'b1, "R9");
    // R4: random frames
    for (int i = 0; i < 4; i++) frame(100 + int'($urandom % 900), 0, 25, 1'b1, "R4");
    // R3: full-scale full frame
    frame(COLS * ROWS, 1, 0, 1'b1, "R3");
    frame(4 * COLS, 2, 10, 1'b1, "R5");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule